// File: doc/BRIEF.md
# Complementary Waveform Generator with Dead Time

The block turns one logic-level signal into a pair of complementary drive signals for a half-bridge or similar output stage. The signal is picked from a bank of single-bit sources by a select field. Channel A is active while the picked signal is high and channel B is active while it is low. Each channel turns on only after the opposite channel has turned off plus a programmable number of dead-time clock ticks, so the two drives never overlap. The dead-time counters advance either on every system clock or on rising edges of a slower oscillator input, which is synchronised inside the block.

Each channel has its own polarity, its own output enable (reported as a per-pin valid flag) and its own shutdown override level. A shutdown input forces both pins to their override levels at the next clock. The pins then stay at those levels until a software clear strobe arrives or, when auto-restart is selected, until the first edge of the picked source after the shutdown input has dropped. Dropping the module enable silences both pins and both valid flags.

Top module: `cwg_top`

## Requirements
- R1: Channel A follows bit `src_sel_i` of `src_i` (index 0 to 7) and channel B follows its complement. With zero dead time and no shutdown, a change of the picked bit reaches `out_a_o` and `out_b_o` on the third rising clock edge after the change.
- R2: The internal active states of A and B are never both asserted, so with both polarities set the two output pins are never both high outside shutdown.
- R3: After B's active state clears, A's active state sets once `db_rise_i` dead-time ticks have elapsed. With ticks on every clock, this leaves exactly `db_rise_i` cycles in which both pins are inactive.
- R4: In the same way, `db_fall_i` ticks pass between A clearing and B setting.
- R5: A dead-time value of 0 sets the incoming channel on the same clock edge on which the outgoing channel clears.
- R6: If the picked source reverses before a dead-time count has finished, the pending turn-on is dropped and counting starts over for the other channel. A source that toggles faster than the dead time keeps both channels inactive.
- R7: With `db_clk_sel_i`=0 the dead-time counters advance on every clock. With `db_clk_sel_i`=1 they advance once per rising edge of `osc_i`, seen through a two-flop synchroniser followed by an edge detector.
- R8: On the first two clock edges after `en_i` rises, both channels' active states are clear.
- R9: `valid_a_o` and `valid_b_o` each register `en_i & oe_a_i` and `en_i & oe_b_i` on every clock.
- R10: While `en_i` is low, the pins and valid flags read 0 one edge later, and internal state (including a pending shutdown) is cleared.
- R11: With polarity bit 1 a pin is high while its channel is active. With polarity bit 0 it is low while its channel is active.
- R12: At the clock edge that samples `shdn_i` high while enabled, the pins take `ovr_a_i` and `ovr_b_i` unchanged by polarity, and both channels' active states clear.
- R13: With `auto_restart_i`=1 the shutdown ends on the clock edge at which the registered source shows its first change after `shdn_i` has gone low. Source changes while `shdn_i` is high do not end it.
- R14: With `auto_restart_i`=0 the shutdown lasts, whatever the source does, until `shdn_clr_i` is sampled high while `shdn_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Module enable |
| src_i | input | 8 | Candidate source bits (already synchronous) |
| src_sel_i | input | 3 | Index of the source bit to use |
| db_clk_sel_i | input | 1 | Dead-time tick select: 0 system clock, 1 oscillator edges |
| osc_i | input | 1 | Slow oscillator used as dead-time tick when selected |
| db_rise_i | input | 6 | Dead time before A turns on, in ticks |
| db_fall_i | input | 6 | Dead time before B turns on, in ticks |
| oe_a_i | input | 1 | Pin enable for channel A |
| oe_b_i | input | 1 | Pin enable for channel B |
| pol_a_i | input | 1 | Channel A polarity, 1 active-high |
| pol_b_i | input | 1 | Channel B polarity, 1 active-high |
| ovr_a_i | input | 1 | Level of pin A during shutdown |
| ovr_b_i | input | 1 | Level of pin B during shutdown |
| shdn_i | input | 1 | Shutdown request |
| auto_restart_i | input | 1 | 1 resumes on a source edge, 0 needs a clear strobe |
| shdn_clr_i | input | 1 | Clear strobe that ends a latched shutdown |
| out_a_o | output | 1 | Drive level for pin A |
| out_b_o | output | 1 | Drive level for pin B |
| valid_a_o | output | 1 | Block claims control of pin A |
| valid_b_o | output | 1 | Block claims control of pin B |

## Verification
Two things can land on the same clock edge: a source reversal that starts or cancels a dead-time count, and a shutdown that clears both active states. The bench provokes this by raising `shdn_i` while the source keeps toggling. It then releases the shutdown in both restart modes, with and without source edges around the release cycle. A behavioural model, updated on every clock, predicts the pins and valid flags, and each edge is judged against it. Separate scenario checks measure the dead-time gaps, confirm the override levels are held, and confirm that fast toggling never lets either channel through.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
  localparam int CH_N = 2;
  localparam int CH_A = 0;
  localparam int CH_B = 1;
endpackage

// File: rtl/cwg_tick.sv
module cwg_tick #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_i,
  input  logic sel_i,
  output logic tick_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], osc_i};
  end

  assign tick_o = sel_i ? (sh[STAGES-1] & ~sh[STAGES]) : 1'b1;
endmodule

// File: rtl/cwg_dead_band.sv
module cwg_dead_band #(
  parameter int DB_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold_i,
  input  logic            want_i,
  input  logic            tick_i,
  input  logic [DB_W-1:0] count_i,
  output logic            on_o
);
  logic [DB_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold_i || !want_i) begin
      cnt <= '0;
    end else if (tick_i && (cnt < count_i)) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || hold_i) on_o <= 1'b0;
    else               on_o <= want_i && (cnt >= count_i);
  end
endmodule

// File: rtl/cwg_shutdown.sv
module cwg_shutdown (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic shdn_i,
  input  logic auto_i,
  input  logic clr_i,
  input  logic edge_i,
  output logic force_o
);
  logic latched;
  logic release_req;

  assign release_req = auto_i ? edge_i : clr_i;
  assign force_o     = shdn_i | latched;

  always_ff @(posedge clk) begin
    if (rst) latched <= 1'b0;
    else     latched <= en_i && (shdn_i || (latched && !release_req));
  end
endmodule

// File: rtl/cwg_top.sv
module cwg_top import cwg_pkg::*; #(
  parameter int SRC_N       = 8,
  parameter int DB_W        = 6,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(SRC_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [SRC_N-1:0] src_i,
  input  logic [SEL_W-1:0] src_sel_i,
  input  logic             db_clk_sel_i,
  input  logic             osc_i,
  input  logic [DB_W-1:0]  db_rise_i,
  input  logic [DB_W-1:0]  db_fall_i,
  input  logic             oe_a_i,
  input  logic             oe_b_i,
  input  logic             pol_a_i,
  input  logic             pol_b_i,
  input  logic             ovr_a_i,
  input  logic             ovr_b_i,
  input  logic             shdn_i,
  input  logic             auto_restart_i,
  input  logic             shdn_clr_i,
  output logic             out_a_o,
  output logic             out_b_o,
  output logic             valid_a_o,
  output logic             valid_b_o
);
  logic            armed;
  logic            in_q;
  logic            in_prev;
  logic            src_edge;
  logic            force_sd;
  logic            hold;
  logic            db_tick;
  logic [CH_N-1:0] want;
  logic [CH_N-1:0] ch_on;
  logic [CH_N-1:0] pol;
  logic [CH_N-1:0] ovr;
  logic [CH_N-1:0] oe;
  logic [CH_N-1:0] out_q;
  logic [CH_N-1:0] valid_q;
  logic [DB_W-1:0] count [CH_N];

  // source pick and edge history
  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      armed   <= 1'b0;
      in_q    <= 1'b0;
      in_prev <= 1'b0;
    end else begin
      armed   <= 1'b1;
      in_q    <= src_i[src_sel_i];
      in_prev <= in_q;
    end
  end

  assign src_edge = in_q ^ in_prev;
  assign hold     = !en_i || !armed || force_sd;

  cwg_tick #(.STAGES(SYNC_STAGES)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .osc_i  (osc_i),
    .sel_i  (db_clk_sel_i),
    .tick_o (db_tick)
  );

  cwg_shutdown u_sd (
    .clk     (clk),
    .rst     (rst),
    .en_i    (en_i),
    .shdn_i  (shdn_i),
    .auto_i  (auto_restart_i),
    .clr_i   (shdn_clr_i),
    .edge_i  (src_edge),
    .force_o (force_sd)
  );

  assign want[CH_A]  = in_q;
  assign want[CH_B]  = ~in_q;
  assign count[CH_A] = db_rise_i;
  assign count[CH_B] = db_fall_i;
  assign pol         = {pol_b_i, pol_a_i};
  assign ovr         = {ovr_b_i, ovr_a_i};
  assign oe          = {oe_b_i, oe_a_i};

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    cwg_dead_band #(.DB_W(DB_W)) u_db (
      .clk     (clk),
      .rst     (rst),
      .hold_i  (hold),
      .want_i  (want[c]),
      .tick_i  (db_tick),
      .count_i (count[c]),
      .on_o    (ch_on[c])
    );
  end

  // registered pin stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      valid_q <= '0;
    end else begin
      for (int c = 0; c < CH_N; c++) begin
        valid_q[c] <= en_i & oe[c];
        if (!en_i)         out_q[c] <= 1'b0;
        else if (force_sd) out_q[c] <= ovr[c];
        else               out_q[c] <= ~(ch_on[c] ^ pol[c]);
      end
    end
  end

  assign out_a_o   = out_q[CH_A];
  assign out_b_o   = out_q[CH_B];
  assign valid_a_o = valid_q[CH_A];
  assign valid_b_o = valid_q[CH_B];
endmodule

// File: rtl/cwg_checker.sv
module cwg_checker (
  input logic clk,
  input logic rst,
  input logic en_i,
  input logic shdn_i,
  input logic ovr_a_i,
  input logic ovr_b_i,
  input logic oe_a_i,
  input logic oe_b_i,
  input logic on_a,
  input logic on_b,
  input logic out_a_o,
  input logic out_b_o,
  input logic valid_a_o,
  input logic valid_b_o
);
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(on_a && on_b)); // R2

  AST_ENABLE_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $rose(en_i) |=> (!on_a && !on_b)); // R8

  AST_VALID_TRACKS_OE: assert property (@(posedge clk) disable iff (rst)
    en_i |=> (valid_a_o == $past(oe_a_i) && valid_b_o == $past(oe_b_i))); // R9

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!valid_a_o && !valid_b_o && !out_a_o && !out_b_o)); // R10

  AST_SHDN_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
    (en_i && shdn_i) |=> (out_a_o == $past(ovr_a_i) && out_b_o == $past(ovr_b_i)
                          && !on_a && !on_b)); // R12
endmodule

bind cwg_top cwg_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .en_i      (en_i),
  .shdn_i    (shdn_i),
  .ovr_a_i   (ovr_a_i),
  .ovr_b_i   (ovr_b_i),
  .oe_a_i    (oe_a_i),
  .oe_b_i    (oe_b_i),
  .on_a      (ch_on[0]),
  .on_b      (ch_on[1]),
  .out_a_o   (out_a_o),
  .out_b_o   (out_b_o),
  .valid_a_o (valid_a_o),
  .valid_b_o (valid_b_o)
);

// File: tb/tb_cwg_top.sv
`timescale 1ns/1ps
module tb_cwg_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 0, db_clk_sel = 0, osc = 0;
  logic [7:0] src = 0;
  logic [2:0] sel = 0;
  logic [5:0] db_rise = 0, db_fall = 0;
  logic       oe_a = 0, oe_b = 0, pol_a = 1, pol_b = 1, ovr_a = 0, ovr_b = 0;
  logic       shdn = 0, auto_rs = 0, clr = 0;
  logic       out_a, out_b, valid_a, valid_b;

  cwg_top dut (
    .clk(clk), .rst(rst), .en_i(en), .src_i(src), .src_sel_i(sel),
    .db_clk_sel_i(db_clk_sel), .osc_i(osc), .db_rise_i(db_rise), .db_fall_i(db_fall),
    .oe_a_i(oe_a), .oe_b_i(oe_b), .pol_a_i(pol_a), .pol_b_i(pol_b),
    .ovr_a_i(ovr_a), .ovr_b_i(ovr_b), .shdn_i(shdn), .auto_restart_i(auto_rs),
    .shdn_clr_i(clr), .out_a_o(out_a), .out_b_o(out_b),
    .valid_a_o(valid_a), .valid_b_o(valid_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // slow oscillator: toggles every 3 clocks
  always begin
    repeat (3) @(posedge clk);
    #1 osc = ~osc;
  end

  int    tests = 0, fails = 0, cycles = 0;
  string phase = "R10";
  bit    chk_overlap = 0;
  bit    done = 0;

  // behavioural reference model
  int m_ok, m_inq, m_inp, m_sd, m_rc, m_fc, m_a, m_b;
  int m_oa, m_ob, m_va, m_vb, m_o1, m_o2, m_o3;

  always @(posedge clk) begin
    int tk, frc, hld, rel, n_rc, n_fc, n_a, n_b, n_sd;
    if (rst) begin
      m_ok = 0; m_inq = 0; m_inp = 0; m_sd = 0; m_rc = 0; m_fc = 0;
      m_a = 0; m_b = 0; m_oa = 0; m_ob = 0; m_va = 0; m_vb = 0;
      m_o1 = 0; m_o2 = 0; m_o3 = 0;
    end else begin
      tk  = db_clk_sel ? (m_o2 == 1 && m_o3 == 0) : 1;
      frc = (shdn || m_sd != 0) ? 1 : 0;
      hld = (!en || m_ok == 0 || frc != 0) ? 1 : 0;
      rel = auto_rs ? (m_inq != m_inp) : int'(clr);
      n_sd = (en && (shdn || (m_sd != 0 && rel == 0))) ? 1 : 0;
      n_rc = (hld != 0 || m_inq == 0) ? 0 : ((tk != 0 && m_rc < db_rise) ? m_rc + 1 : m_rc);
      n_fc = (hld != 0 || m_inq == 1) ? 0 : ((tk != 0 && m_fc < db_fall) ? m_fc + 1 : m_fc);
      n_a  = (hld == 0 && m_inq == 1 && m_rc >= db_rise) ? 1 : 0;
      n_b  = (hld == 0 && m_inq == 0 && m_fc >= db_fall) ? 1 : 0;
      if (!en) begin
        m_oa = 0; m_ob = 0;
      end else if (frc != 0) begin
        m_oa = ovr_a; m_ob = ovr_b;
      end else begin
        m_oa = pol_a ? m_a : 1 - m_a;
        m_ob = pol_b ? m_b : 1 - m_b;
      end
      m_va = en & oe_a; m_vb = en & oe_b;
      m_a = n_a; m_b = n_b; m_rc = n_rc; m_fc = n_fc; m_sd = n_sd;
      m_inp = en ? m_inq : 0;
      m_inq = en ? int'(src[sel]) : 0;
      m_ok  = en ? 1 : 0;
      m_o3 = m_o2; m_o2 = m_o1; m_o1 = osc;
    end
  end

  // gap monitor (valid with both polarities high)
  int gap = 0, gap_a = -1, gap_b = -1;
  logic pa = 0, pb = 0;

  always @(negedge clk) begin
    tests++;
    if (out_a !== m_oa[0] || out_b !== m_ob[0] || valid_a !== m_va[0] || valid_b !== m_vb[0]) begin
      fails++;
      $display("FAIL %s model compare: actual a=%b b=%b va=%b vb=%b expected a=%0d b=%0d va=%0d vb=%0d",
               phase, out_a, out_b, valid_a, valid_b, m_oa, m_ob, m_va, m_vb);
    end
    if (chk_overlap) begin
      tests++;
      if (out_a && out_b) begin
        fails++;
        $display("FAIL R2 overlap: actual a=%b b=%b expected not both 1", out_a, out_b);
      end
    end
    if (!out_a && !out_b) gap++;
    if (out_a && !pa) gap_a = gap;
    if (out_b && !pb) gap_b = gap;
    if (out_a || out_b) gap = 0;
    pa = out_a; pb = out_b;
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // n cycles, checking the two pins at each negedge
  task automatic hold_chk(int n, int ea, int eb, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(out_a == ea[0] && out_b == eb[0], tag, {out_a, out_b}, {ea[0], eb[0]});
      @(posedge clk); #1;
    end
  endtask

  task automatic square(int hi, int lo, int n);
    for (int i = 0; i < n; i++) begin
      src[sel] = 1; cyc(hi);
      src[sel] = 0; cyc(lo);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      summary();
    end
  end

  logic [7:0] lf = 8'h5A;

  initial begin
    // R10: reset state
    cyc(4);
    @(negedge clk);
    chk(out_a == 0 && out_b == 0 && valid_a == 0 && valid_b == 0, "R10 reset", {out_a, out_b, valid_a, valid_b}, 0);
    @(posedge clk); #1;
    rst = 0;
    cyc(2);

    // R8: first enable
    phase = "R8";
    oe_a = 1; oe_b = 1; pol_a = 1; pol_b = 1; sel = 0; src = 0; chk_overlap = 1;
    en = 1;
    hold_chk(2, 0, 0, "R8 start cleared");
    cyc(4);

    // R1: every select value
    phase = "R1";
    for (int s = 0; s < 8; s++) begin
      sel = s[2:0];
      for (int i = 0; i < 10; i++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        src = lf; cyc(1);
      end
      src = 8'd1 << s; cyc(3);
      hold_chk(3, 1, 0, "R1 A follows pick");
      src = ~(8'd1 << s); cyc(3);
      hold_chk(3, 0, 1, "R1 B follows complement");
    end

    // R3 / R4: dead-time gaps
    phase = "R3"; sel = 2; src = 0;
    db_rise = 5; db_fall = 9;
    square(20, 20, 3);
    chk(gap_a == 5, "R3 rise gap", gap_a, 5);
    chk(gap_b == 9, "R4 fall gap", gap_b, 9);

    // R5: zero dead time
    phase = "R5"; db_rise = 0; db_fall = 0;
    square(10, 10, 2);
    chk(gap_a == 0, "R5 zero gap A", gap_a, 0);
    chk(gap_b == 0, "R5 zero gap B", gap_b, 0);

    // R6: fast toggling cancels turn-on
    phase = "R6"; db_rise = 20; db_fall = 20;
    src[sel] = 1; cyc(4);
    for (int i = 0; i < 6; i++) begin
      src[sel] = ~src[sel];
      hold_chk(8, 0, 0, "R6 cancelled");
    end

    // R7: oscillator-driven dead time
    phase = "R7"; db_clk_sel = 1; db_rise = 3; db_fall = 3;
    square(30, 30, 2);
    chk(gap_a >= 12, "R7 slow tick rise gap", gap_a, 12);
    chk(gap_b >= 12, "R7 slow tick fall gap", gap_b, 12);
    db_clk_sel = 0;

    // R11: polarity
    phase = "R11"; chk_overlap = 0; db_rise = 2; db_fall = 2;
    pol_a = 0; pol_b = 1;
    square(10, 10, 2);
    pol_a = 0; pol_b = 0;
    src[sel] = 1; cyc(8);
    hold_chk(2, 0, 1, "R11 active-low");
    pol_a = 1; pol_b = 1; chk_overlap = 1;
    cyc(3);

    // R9: output enables
    phase = "R9";
    oe_a = 0; oe_b = 1; cyc(1);
    @(negedge clk);
    chk(valid_a == 0 && valid_b == 1, "R9 valid A off", {valid_a, valid_b}, 1);
    @(posedge clk); #1;
    oe_a = 1; oe_b = 0; cyc(1);
    @(negedge clk);
    chk(valid_a == 1 && valid_b == 0, "R9 valid B off", {valid_a, valid_b}, 2);
    @(posedge clk); #1;
    oe_b = 1;

    // R12 + R14: shutdown, manual release
    phase = "R12"; chk_overlap = 0;
    ovr_a = 1; ovr_b = 0; pol_a = 0; pol_b = 0; auto_rs = 0;
    square(6, 6, 1);
    src[sel] = 1; shdn = 1;
    hold_chk(2, 1, 0, "R12 override no polarity");
    src[sel] = 0;
    hold_chk(3, 1, 0, "R12 override with source edge");
    shdn = 0; phase = "R14";
    for (int i = 0; i < 4; i++) begin
      src[sel] = ~src[sel];
      hold_chk(4, 1, 0, "R14 latched");
    end
    clr = 1; cyc(1); clr = 0;
    src[sel] = 1; cyc(10);
    hold_chk(2, 0, 1, "R14 resumed");

    // R13: auto-restart
    phase = "R13"; auto_rs = 1; pol_a = 1; pol_b = 1; db_rise = 0; db_fall = 0;
    ovr_a = 0; ovr_b = 1;
    shdn = 1;
    for (int i = 0; i < 4; i++) begin
      src[sel] = ~src[sel];
      hold_chk(3, 0, 1, "R13 edges under shutdown");
    end
    src[sel] = 1; cyc(3);
    shdn = 0;
    hold_chk(5, 0, 1, "R13 awaits edge");
    src[sel] = 0; cyc(2);
    src[sel] = 1; cyc(4);
    hold_chk(3, 1, 0, "R13 resumed");
    square(5, 5, 2);

    // R10: disable mid-run
    phase = "R10";
    en = 0; cyc(1);
    hold_chk(4, 0, 0, "R10 disabled pins");
    @(negedge clk);
    chk(valid_a == 0 && valid_b == 0, "R10 disabled valid", {valid_a, valid_b}, 0);
    @(posedge clk); #1;

    done = 1;
    summary();
  end
endmodule